// File: doc/BRIEF.md
# Two-Wire Register Slave with Auto-Incrementing Subaddress

This block lets a host on a two-wire serial bus read and write a bank of 8-bit control registers. It runs on an oversampled system clock. SCL and SDA are synchronized and cleaned, and the block detects START and STOP conditions. It responds to one 7-bit device address, whose least significant bit comes from a strap input. The open-drain SDA driver appears as an output-enable: when the enable is high, the pad pulls the line low.

After the address byte, the first byte of a write loads a subaddress pointer. Each following data byte goes to the pointed register, and the pointer then steps up by one. A read starts at the current pointer and steps up in the same way. Running past the top of the bank behaves differently for reads and writes. Four consecutive registers form a group, and a 32-bit word built from them updates only when the group's last byte is written. The strap also selects whether a short-pulse filter sits in front of the bus logic.

Top module: `i2c_reg_slave`

## Requirements
- R1: The device address is {ADDR_HI, addrStrap}, sent MSB first, followed by a direction bit in the LSB (1 = read, 0 = write). On a match, the block drives SDA low (sdaOe = 1) during the ninth clock.
- R2: On an address mismatch, the block does not acknowledge. It ignores every later byte until the next START.
- R3: In a write, the byte after the address loads the subaddress pointer and is acknowledged when it is below NUM_REGS.
- R4: Each further data byte of a write is stored at the pointer, acknowledged, and followed by a pointer increment.
- R5: A read returns registers starting at the pointer, in ascending order, MSB first. sdaOe changes only while SCL is low.
- R6: A subaddress of NUM_REGS or more is not acknowledged, and the block returns to idle.
- R7: A read that runs past the top register keeps returning that register's contents until the master does not acknowledge. SDA is then released.
- R8: A write byte aimed past the top register is not stored and is not acknowledged, and the block returns to idle.
- R9: The group occupies registers GRP_BASE to GRP_BASE+3. freqWord changes only when register GRP_BASE+3 is written, and it then becomes {reg GRP_BASE+3, reg +2, reg +1, reg GRP_BASE}.
- R10: A START or STOP in the middle of a byte drops the partial byte and releases SDA. A START begins a new address phase, and a STOP returns the block to idle.
- R11: With addrStrap = 0, a pulse on SCL or SDA shorter than FILT_CYC system clocks is ignored.
- R12: With addrStrap = 1, the filter is bypassed, so a pulse of a few clocks on SCL counts as a clock edge.
- R13: After reset, sdaOe is 0, freqWord is 0, the registers are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| addrStrap | input | 1 | Address LSB; 0 also enables the pulse filter |
| sdaOe | output | 1 | Pull SDA low when 1 |
| freqWord | output | 32 | Committed 32-bit group value |

## Verification
The bench targets the following corner cases:

- **Pointer at the top of the bank.** A design that wraps the pointer would corrupt register 0 on a write overrun, or return register 0 on a read overrun, instead of holding on the top register.
- **Group commit.** Writing only the first three bytes of the group must leave freqWord unchanged. A design that commits byte by byte fails this at once.
- **Mid-byte START and STOP.** A design that keeps a half-received byte, or advances the pointer on it, reads back the wrong register after a repeated START.
- **Glitch on SCL.** With the strap at 0, a 2-cycle SCL pulse during the address must leave the acknowledge intact. With the strap at 1, the same pulse must shift the address by one bit and cause a NACK, which exposes a filter that ignores the strap.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } slvState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       loadPtr;
    logic       incPtr;
    logic       wrEn;
    logic [7:0] byteVal;
  } dpStrobe_t;

  // datapath -> control bus events (one system clock wide)
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaVal;
  } busEvt_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic bypass,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;
  logic             filtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      filtQ  <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (bypass) begin
        filtQ  <= syncQ[1];
        runCnt <= '0;
      end else if (syncQ[1] == filtQ) begin
        runCnt <= '0;
      end else if (runCnt == CNT_W'(FILT_CYC - 1)) begin
        // new level held for FILT_CYC consecutive clocks
        filtQ  <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign cleanOut = filtQ;
endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int GRP_BASE = 4,
  parameter int FILT_CYC = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        filtBypass,
  input  dpStrobe_t   strb,
  output busEvt_t     evt,
  output logic [7:0]  rdByte,
  output logic        ptrValid,
  output logic [31:0] freqWord
);
  localparam int         IDX_W     = $clog2(NUM_REGS);
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);
  localparam logic [7:0] GRP_TOP   = 8'(GRP_BASE + 3);

  logic [1:0] rawLine, cleanLine;
  logic       sclD, sdaD;
  logic [7:0] regBank [NUM_REGS];
  logic [7:0] ptr;
  logic [31:0] freqQ;

  assign rawLine = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) uFilt (
      .clk(clk), .rstN(rstN), .bypass(filtBypass),
      .rawIn(rawLine[g]), .cleanOut(cleanLine[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= cleanLine[1];
      sdaD <= cleanLine[0];
    end
  end

  always_comb begin
    evt.start   = sclD & cleanLine[1] & sdaD & ~cleanLine[0];
    evt.stop    = sclD & cleanLine[1] & ~sdaD & cleanLine[0];
    evt.sclRise = cleanLine[1] & ~sclD;
    evt.sclFall = ~cleanLine[1] & sclD;
    evt.sdaVal  = cleanLine[0];
  end

  assign ptrValid = ptr < REG_LIMIT;
  // past the top, reads keep returning the highest register
  assign rdByte   = ptrValid ? regBank[ptr[IDX_W-1:0]] : regBank[NUM_REGS-1];
  assign freqWord = freqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
      ptr   <= '0;
      freqQ <= '0;
    end else begin
      if (strb.loadPtr)                ptr <= strb.byteVal;
      else if (strb.incPtr && ptrValid) ptr <= ptr + 8'd1;
      if (strb.wrEn && ptrValid) regBank[ptr[IDX_W-1:0]] <= strb.byteVal;
      if (strb.wrEn && ptr == GRP_TOP)
        freqQ <= {strb.byteVal, regBank[GRP_BASE+2], regBank[GRP_BASE+1], regBank[GRP_BASE]};
    end
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter logic [5:0] ADDR_HI  = 6'b010110,
  parameter int         NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrStrap,
  input  busEvt_t    evt,
  input  logic [7:0] rdByte,
  input  logic       ptrValid,
  output dpStrobe_t  strb,
  output logic       sdaOe
);
  localparam logic [7:0] SUB_LIMIT = 8'(NUM_REGS);

  slvState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftQ, txQ;
  logic       isRead, mAck, oeQ;
  logic       byteDone, subOk;
  logic [6:0] devAddr;

  assign devAddr  = {ADDR_HI, addrStrap};
  assign byteDone = evt.sclFall && bitCnt == 4'd8;
  assign subOk    = shiftQ < SUB_LIMIT;
  assign sdaOe    = oeQ;

  always_comb begin
    strb.byteVal = shiftQ;
    strb.loadPtr = state == ST_SUB && byteDone && subOk;
    strb.wrEn    = state == ST_WDATA && byteDone && ptrValid;
    strb.incPtr  = strb.wrEn || (state == ST_RDATA && byteDone);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; shiftQ <= '0; txQ <= '0;
      isRead <= 1'b0; mAck <= 1'b0; oeQ <= 1'b0;
    end else if (evt.start) begin
      state <= ST_ADDR; bitCnt <= '0; oeQ <= 1'b0;
    end else if (evt.stop) begin
      state <= ST_IDLE; oeQ <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (evt.sclRise) begin
            shiftQ <= {shiftQ[6:0], evt.sdaVal};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (state == ST_ADDR && shiftQ[7:1] == devAddr) begin
              state <= ST_ADDR_ACK; oeQ <= 1'b1; isRead <= shiftQ[0];
            end else if (state == ST_SUB && subOk) begin
              state <= ST_SUB_ACK; oeQ <= 1'b1;
            end else if (state == ST_WDATA && ptrValid) begin
              state <= ST_WACK; oeQ <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (evt.sclFall) begin
          bitCnt <= '0;
          if (isRead) begin
            state <= ST_RDATA; txQ <= rdByte; oeQ <= ~rdByte[7];
          end else begin
            state <= ST_SUB; oeQ <= 1'b0;
          end
        end
        ST_SUB_ACK, ST_WACK: if (evt.sclFall) begin
          state <= ST_WDATA; bitCnt <= '0; oeQ <= 1'b0;
        end
        ST_RDATA: begin
          if (evt.sclRise) bitCnt <= bitCnt + 4'd1;
          else if (byteDone) begin
            state <= ST_RACK; oeQ <= 1'b0;
          end else if (evt.sclFall) begin
            txQ <= {txQ[6:0], 1'b0}; oeQ <= ~txQ[6];
          end
        end
        ST_RACK: begin
          if (evt.sclRise) mAck <= ~evt.sdaVal;
          else if (evt.sclFall) begin
            if (mAck) begin
              state <= ST_RDATA; bitCnt <= '0; txQ <= rdByte; oeQ <= ~rdByte[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter logic [5:0] ADDR_HI  = 6'b010110,
  parameter int         NUM_REGS = 16,
  parameter int         GRP_BASE = 4,
  parameter int         FILT_CYC = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        addrStrap,
  output logic        sdaOe,
  output logic [31:0] freqWord
);
  dpStrobe_t  dpStrb;
  busEvt_t    busEvt;
  logic [7:0] rdByte;
  logic       ptrValid;

  i2c_slave_ctrl #(.ADDR_HI(ADDR_HI), .NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .addrStrap(addrStrap), .evt(busEvt),
    .rdByte(rdByte), .ptrValid(ptrValid), .strb(dpStrb), .sdaOe(sdaOe)
  );

  i2c_slave_dp #(.NUM_REGS(NUM_REGS), .GRP_BASE(GRP_BASE), .FILT_CYC(FILT_CYC)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .filtBypass(addrStrap), .strb(dpStrb), .evt(busEvt),
    .rdByte(rdByte), .ptrValid(ptrValid), .freqWord(freqWord)
  );
endmodule

// File: rtl/i2c_slave_checker.sv
module i2c_slave_checker (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaOe,
  input logic        evtStart,
  input logic        evtStop,
  input logic        wrEn,
  input logic        ptrValid,
  input logic [31:0] freqWord
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn); // R5

  AST_NO_STORE_PAST_TOP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ptrValid); // R8

  AST_GROUP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqWord) |-> $past(wrEn)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    evtStop |=> !sdaOe); // R10

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    evtStart |=> !sdaOe); // R10
endmodule

bind i2c_reg_slave i2c_slave_checker uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .evtStart(busEvt.start), .evtStop(busEvt.stop),
  .wrEn(dpStrb.wrEn), .ptrValid(ptrValid), .freqWord(freqWord)
);

// File: tb/i2c_reg_slave_bench.sv
module i2c_reg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;   // quarter SCL period in system clocks
  localparam int NREG       = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, sclGlitch = 1'b0, addrStrap = 1'b0;
  logic sdaOe;
  logic [31:0] freqWord;
  logic sdaLine, sclLine;

  assign sdaLine = sdaM & ~sdaOe;
  assign sclLine = sclM | sclGlitch;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave u_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .addrStrap(addrStrap), .sdaOe(sdaOe), .freqWord(freqWord)
  );

  int checks = 0, failures = 0;
  bit busy = 1'b1;
  logic [7:0] mReg [NREG];
  int mPtr = 0;
  logic [31:0] mFreq = '0;
  logic [7:0] wq [$];
  logic [7:0] devW = 8'h58, devR = 8'h59;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison against the model while the bus is quiet
  always @(negedge clk) begin
    if (rstN && !busy) begin
      check(freqWord == mFreq, "R9 idle freqWord", freqWord, mFreq);
      check(sdaOe == 1'b0, "R10 idle sdaOe", 32'(sdaOe), 0);
    end
  end

  function automatic bit modelWrite(input logic [7:0] b);
    if (mPtr >= NREG) return 1'b0;
    mReg[mPtr] = b;
    if (mPtr == 7) mFreq = {b, mReg[6], mReg[5], mReg[4]};
    mPtr++;
    return 1'b1;
  endfunction

  function automatic logic [7:0] modelRead();
    logic [7:0] v;
    v = mReg[(mPtr < NREG) ? mPtr : NREG-1];
    if (mPtr < NREG) mPtr++;
    return v;
  endfunction

  task automatic startCond();
    busy = 1'b1;
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    sdaM = 1'b1; waitClk(2*Q);
    busy = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i];
      if (glitch && i == 7) begin
        waitClk(5); sclGlitch = 1'b1; waitClk(2); sclGlitch = 1'b0; waitClk(Q - 7);
      end else waitClk(Q);
      sclM = 1'b1; waitClk(2*Q);
      sclM = 1'b0; waitClk(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    sendBits(b, 8, glitch);
    sdaM = 1'b1; waitClk(Q);
    sclM = 1'b1; waitClk(Q);
    ack = !sdaLine; waitClk(Q);
    sclM = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      waitClk(Q); sclM = 1'b1; waitClk(Q);
      b = {b[6:0], sdaLine};
      waitClk(Q); sclM = 1'b0; waitClk(Q);
    end
    sdaM = !giveAck; waitClk(Q);
    sclM = 1'b1; waitClk(2*Q);
    sclM = 1'b0; waitClk(Q);
    sdaM = 1'b1;
  endtask

  task automatic wrTxn(input logic [7:0] sub, input string req);
    bit ack, exp;
    startCond();
    sendByte(devW, 1'b0, ack); check(ack, {req, " addr ack"}, 32'(ack), 1);
    exp = sub < NREG;
    sendByte(sub, 1'b0, ack); check(ack == exp, {req, " sub ack"}, 32'(ack), 32'(exp));
    if (exp) begin
      mPtr = sub;
      foreach (wq[i]) begin
        exp = modelWrite(wq[i]);
        sendByte(wq[i], 1'b0, ack);
        check(ack == exp, {req, " data ack"}, 32'(ack), 32'(exp));
        if (!exp) break;
      end
    end else begin
      sendByte(8'h55, 1'b0, ack); check(!ack, {req, " idle after bad sub"}, 32'(ack), 0);
    end
    stopCond();
    wq.delete();
  endtask

  task automatic rdTxn(input int n, input string req);
    bit ack;
    logic [7:0] b, e;
    startCond();
    sendByte(devR, 1'b0, ack); check(ack, {req, " read addr ack"}, 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      e = modelRead();
      recvByte(i < n - 1, b);
      check(b == e, {req, " read data"}, 32'(b), 32'(e));
    end
    stopCond();
    check(sdaOe == 1'b0, {req, " released"}, 32'(sdaOe), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) mReg[i] = '0;
    waitClk(10);
    check(sdaOe == 1'b0, "R13 reset sdaOe", 32'(sdaOe), 0);
    check(freqWord == 0, "R13 reset freqWord", freqWord, 0);
    rstN = 1'b1; waitClk(10);
    busy = 1'b0;
    waitClk(20);

    // R2: wrong address (strap-1 code while strap is 0), later byte also ignored
    startCond();
    sendByte(8'h5A, 1'b0, ack); check(!ack, "R2 mismatch nack", 32'(ack), 0);
    sendByte(8'h00, 1'b0, ack); check(!ack, "R2 ignores rest", 32'(ack), 0);
    stopCond();
    rdTxn(1, "R13 reset reg0");

    // R1 R3 R4: burst write from 0
    wq = '{8'hA5, 8'h3C, 8'h0F, 8'h81};
    wrTxn(8'h00, "R4 burst write");
    wrTxn(8'h00, "R3 set ptr");
    rdTxn(4, "R5 burst read");

    // R6: invalid subaddress
    wrTxn(8'h20, "R6 bad sub");

    // R8: write overrun
    wq = '{8'h11, 8'h22, 8'h33};
    wrTxn(8'd14, "R8 overrun write");
    wrTxn(8'h00, "R8 set ptr");
    rdTxn(1, "R8 reg0 untouched");

    // R7: read overrun repeats top register
    wrTxn(8'd14, "R7 set ptr");
    rdTxn(4, "R7 overrun read");

    // R9: group commit
    wq = '{8'h78, 8'h56, 8'h34};
    wrTxn(8'd4, "R9 partial group");
    check(freqWord == 0, "R9 no commit before top byte", freqWord, 0);
    wq = '{8'h12};
    wrTxn(8'd7, "R9 top byte");
    check(freqWord == 32'h12345678, "R9 commit", freqWord, 32'h12345678);
    wq = '{8'hEF, 8'hBE, 8'hAD, 8'hDE};
    wrTxn(8'd4, "R9 full group");
    check(freqWord == 32'hDEADBEEF, "R9 commit burst", freqWord, 32'hDEADBEEF);

    // R10: repeated START mid data byte, then STOP mid address
    startCond();
    sendByte(devW, 1'b0, ack); check(ack, "R10 addr", 32'(ack), 1);
    sendByte(8'd2, 1'b0, ack); check(ack, "R10 sub", 32'(ack), 1);
    mPtr = 2;
    sendBits(8'hFF, 4, 1'b0);
    startCond();
    sendByte(devR, 1'b0, ack); check(ack, "R10 restart addr", 32'(ack), 1);
    recvByte(1'b0, b);
    check(b == 8'h0F, "R10 partial byte dropped", 32'(b), 32'h0F);
    mPtr = 3;
    stopCond();
    startCond();
    sendBits(devW, 4, 1'b0);
    stopCond();
    rdTxn(1, "R10 after stop mid address");

    // R11: filtered SCL glitch during address
    startCond();
    sendByte(devW, 1'b1, ack); check(ack, "R11 glitch filtered", 32'(ack), 1);
    sendByte(8'h00, 1'b0, ack); check(ack, "R11 sub after glitch", 32'(ack), 1);
    mPtr = 0;
    stopCond();

    // R12 and R1 strap: address moves, filter bypassed
    addrStrap = 1'b1; devW = 8'h5A; devR = 8'h5B;
    waitClk(20);
    startCond();
    sendByte(8'h58, 1'b0, ack); check(!ack, "R1 strap changes address", 32'(ack), 0);
    stopCond();
    startCond();
    sendByte(devW, 1'b1, ack); check(!ack, "R12 glitch counted", 32'(ack), 0);
    stopCond();
    wq = '{8'hC3};
    wrTxn(8'd1, "R1 strap-1 write");
    wrTxn(8'd1, "R1 strap-1 ptr");
    rdTxn(1, "R1 strap-1 read");

    waitClk(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule